// File: doc/BRIEF.md
# Quadrature Encoder Up/Down Counter

This block counts the motion of an incremental encoder. It takes two raw encoder lines, A and B, and re-times both into the local clock. It then finds their edges and steps a counter up or down. Three encoder modes are available. In the first, edges on A are counted and the level of B gives the direction. The second mode swaps the roles of the two lines. The third decodes both lines as a full quadrature pair, so one encoder line gives four counts. A mode code of zero, or any code above three, stops encoder counting.

A programmable limit ("preset") sets the period of the counter. An up count wraps from the limit to zero, and a down count reloads the limit when it leaves zero. Each wrap or reload raises a one-cycle event pulse. The preset can be double-buffered, so that a new limit only takes effect at the next wrap or reload. Software reaches the counter, the preset, the direction flag and the mode through a small register port. Writes happen in one cycle; reads are combinational.

Top module: `qenc_counter`

## Requirements
- R1: After reset the counter reads 0, the preset reads all ones, the mode reads 0, the control word reads 0 (direction up, preload off), and no event has fired.
- R2: With mode code 0 (at address 0x08, bits 2:0), changes on A and B leave the counter unchanged.
- R3: With mode code 1, the counter steps on every edge of A, and edges of B alone do not move it. Walking the lines one full forward cycle through the {A,B} sequence 00,01,11,10 adds 2, and walking it backward subtracts 2.
- R4: With mode code 2, the counter steps on every edge of B, and edges of A alone do not move it. One full forward cycle adds 2.
- R5: With mode code 3, every single-line transition steps by one: +1 in the forward order 00,01,11,10 and -1 in the reverse order.
- R6: With mode code 3, a transition in which A and B both change at once is ignored.
- R7: Counting up from a value at or above the active preset gives 0 and one event pulse of one cycle.
- R8: Counting down from 0 loads the active preset and gives one event pulse of one cycle.
- R9: The control word at address 0x00 has the direction flag in bit 4 (0 up, 1 down). In modes 1 to 3 the flag follows the direction of the last counted step, and software writes to the flag are ignored. In any other mode the flag is writable.
- R10: Bit 7 of the control word enables the preset buffer. With the bit at 0, a write to the preset (address 0x2C) takes effect at once. With the bit at 1, the write takes effect at the next wrap or reload. A read of the preset returns the value last written.
- R11: A write to address 0x24 loads the counter directly and takes priority over an encoder step in the same cycle. The mode register keeps any 3-bit code written to it, and codes 4 to 7 count nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| enc_a | input | 1 | Encoder line A, asynchronous |
| enc_b | input | 1 | Encoder line B, asynchronous |
| wr_en | input | 1 | Register write strobe |
| addr | input | 6 | Register address for reads and writes |
| wdata | input | CNT_W | Register write data |
| rdata | output | CNT_W | Register read data, combinational from addr |
| evt_o | output | 1 | One-cycle pulse on every wrap or reload |

## Verification
A corrupt counter or active preset shows up at the counter read port within one register read. It also shows as a missing, extra or early event pulse at the next wrap. A bad edge history in the synchronizer shows three clocks after an input change, as a count that moved in the wrong mode or by the wrong amount. A stuck direction flag shows in the control word after the next step against the previous direction. A preset buffer that loads at the wrong time shows as a wrap at the old or new limit one period too early or too late.

// File: rtl/qenc_pkg.sv
// Package: shared constants and types for the quadrature counter.
// Assumes: register addresses are byte offsets on a 6-bit address.
package qenc_pkg;
    localparam int ADDR_W = 6;

    localparam logic [ADDR_W-1:0] ADR_CTRL = 6'h00;
    localparam logic [ADDR_W-1:0] ADR_MODE = 6'h08;
    localparam logic [ADDR_W-1:0] ADR_CNT  = 6'h24;
    localparam logic [ADDR_W-1:0] ADR_PRE  = 6'h2C;

    localparam int DIR_BIT = 4;
    localparam int APE_BIT = 7;

    typedef enum logic [2:0] {
        MD_OFF  = 3'd0,
        MD_A    = 3'd1,
        MD_B    = 3'd2,
        MD_QUAD = 3'd3
    } qmode_e;
endpackage

// File: rtl/qenc_sync.sv
// Module: two-flop synchronizer per input bit plus one history flop.
// Assumes: inputs are asynchronous levels; q_now is the re-timed level
// and q_prev is that level one clock earlier, for edge detection.
module qenc_sync #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] din,
    output logic [N-1:0] q_now,
    output logic [N-1:0] q_prev
);
    for (genvar g = 0; g < N; g++) begin : g_bit
        logic meta_q, sync_q, hist_q;

        // Purpose: re-time one input and keep one cycle of history.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                meta_q <= 1'b0;
                sync_q <= 1'b0;
                hist_q <= 1'b0;
            end else begin
                meta_q <= din[g];
                sync_q <= meta_q;
                hist_q <= sync_q;
            end
        end

        assign q_now[g]  = sync_q;
        assign q_prev[g] = hist_q;
    end
endmodule

// File: rtl/qenc_decode.sv
// Module: turns re-timed encoder levels into a step request and direction.
// Assumes: the forward order of {A,B} is 00,01,11,10. Codes outside
// 1..3 give no step. In quadrature mode a two-line change is dropped.
module qenc_decode
    import qenc_pkg::*;
(
    input  logic [2:0] mode,
    input  logic       a_s,
    input  logic       a_p,
    input  logic       b_s,
    input  logic       b_p,
    output logic       step,
    output logic       down
);
    logic a_edge, b_edge;

    assign a_edge = a_s ^ a_p;
    assign b_edge = b_s ^ b_p;

    // Purpose: pick the counting line and the direction for the mode.
    always_comb begin
        step = 1'b0;
        down = 1'b0;
        case (qmode_e'(mode))
            MD_A: begin
                step = a_edge;
                down = a_s ^ b_s;
            end
            MD_B: begin
                step = b_edge;
                down = ~(a_s ^ b_s);
            end
            MD_QUAD: begin
                step = a_edge ^ b_edge;
                down = a_edge ? (a_s ^ b_s) : ~(a_s ^ b_s);
            end
            default: begin
                step = 1'b0;
                down = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/qenc_cnt.sv
// Module: the up/down counter with a wrap limit, a buffered limit and an event.
// Assumes: a software counter write wins over a step in the same cycle.
// The event is registered and appears in the cycle of the new count.
module qenc_cnt #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    input  logic             down,
    input  logic             cnt_we,
    input  logic             pre_we,
    input  logic [CNT_W-1:0] wval,
    input  logic             preload_en,
    output logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] pre_shadow,
    output logic [CNT_W-1:0] pre_active,
    output logic             evt
);
    localparam logic [CNT_W-1:0] ONES = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q, sh_q, act_q, act_nx;
    logic             evt_q, wrap_up, wrap_dn, wrap;

    // Purpose: find a wrap or reload and the limit for the next period.
    always_comb begin
        wrap_up = step && !down && (cnt_q >= act_q);
        wrap_dn = step && down && (cnt_q == '0);
        wrap    = (wrap_up || wrap_dn) && !cnt_we;
        act_nx  = act_q;
        if (pre_we && !preload_en)
            act_nx = wval;
        else if (wrap && preload_en)
            act_nx = sh_q;
    end

    // Purpose: update the count, both preset copies and the event flop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            sh_q  <= ONES;
            act_q <= ONES;
            evt_q <= 1'b0;
        end else begin
            act_q <= act_nx;
            evt_q <= wrap;
            if (pre_we)
                sh_q <= wval;
            if (cnt_we)
                cnt_q <= wval;
            else if (wrap_up)
                cnt_q <= '0;
            else if (wrap_dn)
                cnt_q <= act_nx;
            else if (step)
                cnt_q <= down ? (cnt_q - ONE) : (cnt_q + ONE);
        end
    end

    assign cnt        = cnt_q;
    assign pre_shadow = sh_q;
    assign pre_active = act_q;
    assign evt        = evt_q;
endmodule

// File: rtl/qenc_counter.sv
// Module: top of the quadrature counter. It holds the mode and control
// registers and the read mux, and joins synchronizer, decoder and counter.
// Assumes: CNT_W >= 8, so that the control bits fit in the data word.
module qenc_counter
    import qenc_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enc_a,
    input  logic              enc_b,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [CNT_W-1:0]  wdata,
    output logic [CNT_W-1:0]  rdata,
    output logic              evt_o
);
    logic [1:0]       ab_s, ab_p;
    logic             a_s, a_p, b_s, b_p;
    logic             step_w, down_w, enc_on;
    logic             cnt_we, pre_we, ctrl_we, mode_we;
    logic [2:0]       mode_r;
    logic             dir_r, ape_r;
    logic [CNT_W-1:0] cnt_w, sh_w, act_w, ctrl_rd;

    qenc_sync #(.N(2)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .din    ({enc_a, enc_b}),
        .q_now  (ab_s),
        .q_prev (ab_p)
    );

    assign a_s = ab_s[1];
    assign b_s = ab_s[0];
    assign a_p = ab_p[1];
    assign b_p = ab_p[0];

    qenc_decode u_dec (
        .mode (mode_r),
        .a_s  (a_s),
        .a_p  (a_p),
        .b_s  (b_s),
        .b_p  (b_p),
        .step (step_w),
        .down (down_w)
    );

    assign cnt_we  = wr_en && (addr == ADR_CNT);
    assign pre_we  = wr_en && (addr == ADR_PRE);
    assign ctrl_we = wr_en && (addr == ADR_CTRL);
    assign mode_we = wr_en && (addr == ADR_MODE);
    assign enc_on  = (mode_r != 3'd0) && (mode_r < 3'd4);

    qenc_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .step       (step_w),
        .down       (down_w),
        .cnt_we     (cnt_we),
        .pre_we     (pre_we),
        .wval       (wdata),
        .preload_en (ape_r),
        .cnt        (cnt_w),
        .pre_shadow (sh_w),
        .pre_active (act_w),
        .evt        (evt_o)
    );

    // Purpose: hold the mode code and the preset-buffer enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_r <= 3'd0;
            ape_r  <= 1'b0;
        end else begin
            if (mode_we)
                mode_r <= wdata[2:0];
            if (ctrl_we)
                ape_r <= wdata[APE_BIT];
        end
    end

    // Purpose: direction flag, set by hardware in encoder modes and by software otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)
            dir_r <= 1'b0;
        else if (enc_on) begin
            if (step_w)
                dir_r <= down_w;
        end else if (ctrl_we)
            dir_r <= wdata[DIR_BIT];
    end

    // Purpose: assemble the control word for reads.
    always_comb begin
        ctrl_rd          = '0;
        ctrl_rd[DIR_BIT] = dir_r;
        ctrl_rd[APE_BIT] = ape_r;
    end

    // Purpose: combinational register read mux.
    always_comb begin
        case (addr)
            ADR_CTRL: rdata = ctrl_rd;
            ADR_MODE: rdata = CNT_W'(mode_r);
            ADR_CNT:  rdata = cnt_w;
            ADR_PRE:  rdata = sh_w;
            default:  rdata = '0;
        endcase
    end
endmodule

// File: rtl/qenc_chk.sv
// Checker: temporal properties of the quadrature counter, bound to the top.
module qenc_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             evt,
    input logic             step,
    input logic             dir,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] act,
    input logic [2:0]       mode,
    input logic             cnt_we,
    input logic             a_s,
    input logic             a_p,
    input logic             b_s,
    input logic             b_p
);
    AST_EVT_AFTER_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        evt |-> $past(step));                                                  // R7
    AST_UP_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (evt && !dir) |-> (cnt == '0));                                        // R7
    AST_DOWN_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (evt && dir) |-> (cnt == act));                                        // R8
    AST_OFF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 3'd0 && !cnt_we) |=> $stable(cnt));                           // R2
    AST_DOUBLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 3'd3 && (a_s != a_p) && (b_s != b_p) && !cnt_we) |=> $stable(cnt)); // R6
    AST_DIR_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode != 3'd0) && (mode < 3'd4) && !step) |=> $stable(dir));          // R9
endmodule

bind qenc_counter qenc_chk #(.CNT_W(CNT_W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .evt    (evt_o),
    .step   (step_w),
    .dir    (dir_r),
    .cnt    (cnt_w),
    .act    (act_w),
    .mode   (mode_r),
    .cnt_we (cnt_we),
    .a_s    (a_s),
    .a_p    (a_p),
    .b_s    (b_s),
    .b_p    (b_p)
);

// File: tb/sim_qenc_counter.sv
// Bench: scoreboard for the quadrature counter. Driver tasks push
// expected register reads into queues and a monitor pops and compares them.
module sim_qenc_counter;
    import qenc_pkg::*;
    localparam int W = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              enc_a = 1'b0;
    logic              enc_b = 1'b0;
    logic              wr_en = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic [W-1:0]      wdata = '0;
    logic [W-1:0]      rdata;
    logic              evt_o;

    always #2 clk = ~clk;

    qenc_counter #(.CNT_W(W)) u0 (
        .clk   (clk),
        .rst_n (rst_n),
        .enc_a (enc_a),
        .enc_b (enc_b),
        .wr_en (wr_en),
        .addr  (addr),
        .wdata (wdata),
        .rdata (rdata),
        .evt_o (evt_o)
    );

    int n_chk = 0;
    int n_fail = 0;
    int evt_seen = 0;
    int evt_exp = 0;
    bit done = 1'b0;

    string    q_req[$];
    int       q_exp[$];

    // model state
    int       m_cnt = 0;
    int       m_act = 16'hFFFF;
    int       m_sh = 16'hFFFF;
    int       m_mode = 0;
    bit       m_ape = 1'b0;
    bit       m_dir = 1'b0;
    bit [1:0] ab = 2'b00;

    function automatic void chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endfunction

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    // monitor: compare the read data against the queued expectation
    always @(posedge clk) begin
        #1;
        if (q_exp.size() > 0)
            chk(q_req.pop_front(), int'(rdata), q_exp.pop_front());
    end

    // event counter, sampled away from the active edge
    always @(negedge clk) if (rst_n && evt_o) evt_seen++;

    function automatic int pos_of(bit [1:0] v);
        case (v)
            2'b00: return 0;
            2'b01: return 1;
            2'b11: return 2;
            default: return 3;
        endcase
    endfunction

    function automatic bit [1:0] code_of(int p);
        case (p)
            0: return 2'b00;
            1: return 2'b01;
            2: return 2'b11;
            default: return 2'b10;
        endcase
    endfunction

    task automatic rd(logic [ADDR_W-1:0] a, int exp, string req);
        @(negedge clk);
        addr = a;
        q_req.push_back(req);
        q_exp.push_back(exp);
        @(posedge clk);
        #2;
    endtask

    task automatic wr(logic [ADDR_W-1:0] a, int d);
        @(negedge clk);
        wr_en = 1'b1;
        addr  = a;
        wdata = W'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wr_mode(int m);
        wr(ADR_MODE, m);
        m_mode = m;
    endtask

    task automatic wr_cnt(int v);
        wr(ADR_CNT, v);
        m_cnt = v;
    endtask

    task automatic wr_pre(int v);
        wr(ADR_PRE, v);
        m_sh = v;
        if (!m_ape) m_act = v;
    endtask

    task automatic wr_ctrl(int v);
        wr(ADR_CTRL, v);
        m_ape = v[7];
        if (!(m_mode >= 1 && m_mode <= 3)) m_dir = v[4];
    endtask

    // driver: one single-line step of the encoder, forward or backward
    task automatic move(bit fwd);
        bit [1:0] nw;
        bit       a_chg, counts;
        int       p;
        p = pos_of(ab);
        p = fwd ? (p + 1) % 4 : (p + 3) % 4;
        nw = code_of(p);
        a_chg = (nw[1] != ab[1]);
        counts = (m_mode == 3) || (m_mode == 1 && a_chg) || (m_mode == 2 && !a_chg);
        if (counts) begin
            m_dir = !fwd;
            if (fwd) begin
                if (m_cnt >= m_act) begin
                    m_cnt = 0;
                    evt_exp++;
                    if (m_ape) m_act = m_sh;
                end else m_cnt++;
            end else begin
                if (m_cnt == 0) begin
                    if (m_ape) m_act = m_sh;
                    m_cnt = m_act;
                    evt_exp++;
                end else m_cnt--;
            end
        end
        @(negedge clk);
        enc_a = nw[1];
        enc_b = nw[0];
        ab = nw;
        repeat (5) @(negedge clk);
    endtask

    task automatic moves(bit fwd, int n);
        for (int i = 0; i < n; i++) move(fwd);
    endtask

    task automatic check_state(string req);
        rd(ADR_CNT, m_cnt, req);
        rd(ADR_CTRL, (int'(m_ape) << 7) | (int'(m_dir) << 4), req);
        chk({req, " events"}, evt_seen, evt_exp);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            summary();
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1: reset values
        rd(ADR_CNT, 0, "R1 counter");
        rd(ADR_PRE, 16'hFFFF, "R1 preset");
        rd(ADR_MODE, 0, "R1 mode");
        rd(ADR_CTRL, 0, "R1 control");
        chk("R1 events", evt_seen, 0);

        // R2: mode 0 ignores the encoder
        moves(1'b1, 4);
        check_state("R2");

        // R5: full quadrature, forward then one back
        wr_mode(3);
        moves(1'b1, 4);
        check_state("R5 forward");
        move(1'b0);
        check_state("R5 backward");

        // R6: both lines flip together
        @(negedge clk);
        enc_a = ~ab[1];
        enc_b = ~ab[0];
        ab = ~ab;
        repeat (5) @(negedge clk);
        check_state("R6");

        // R3 and R11: mode 1 after a direct counter load
        wr_mode(1);
        wr_cnt(100);
        rd(ADR_CNT, 100, "R11 load");
        moves(1'b1, 4);
        check_state("R3 forward");
        moves(1'b0, 4);
        check_state("R3 backward");

        // R4: mode 2
        wr_mode(2);
        moves(1'b1, 4);
        check_state("R4");

        // R9: direction flag locked in encoder modes, writable when off
        wr_ctrl(16'h0010);
        check_state("R9 locked");
        wr_mode(0);
        wr_ctrl(16'h0010);
        check_state("R9 writable");
        wr_ctrl(0);
        check_state("R9 cleared");

        // R7 and R8: wrap and reload with an immediate preset
        wr_mode(3);
        wr_pre(5);
        wr_cnt(3);
        moves(1'b1, 2);
        check_state("R7 at limit");
        move(1'b1);
        check_state("R7 wrap");
        move(1'b0);
        check_state("R8 reload");

        // R10: buffered preset
        wr_ctrl(16'h0080);
        wr_cnt(3);
        wr_pre(2);
        rd(ADR_PRE, 2, "R10 readback");
        moves(1'b1, 3);
        check_state("R10 old limit");
        moves(1'b1, 2);
        check_state("R10 new limit reached");
        move(1'b1);
        check_state("R10 new limit wrap");

        // R11: mode codes above 3 count nothing and read back as written
        wr_mode(5);
        rd(ADR_MODE, 5, "R11 mode code");
        moves(1'b1, 2);
        check_state("R11 idle code");

        repeat (4) @(negedge clk);
        done = 1'b1;
        summary();
    end
endmodule